// File: doc/BRIEF.md
# MDIO Management Frame Master

This block drives the two-wire station management bus towards Ethernet PHYs. A host hands it one 32-bit command word; the block turns that word into a single 64-bit management frame, shifts it out on the management clock and data lines, and, for read frames, releases the data line so the PHY can answer. While the frame is on the wire the top bit of the status word reads back as one. Once it clears, the host may issue the next command.

The same command layout covers both frame families. A 2-bit start code selects between them. Value 01 gives the short-address family, with a register number in the 5-bit address field. Value 00 gives the extended family, where that field carries a device number and a separate address frame sets the 16-bit register pointer. The clock on the management bus is derived from the system clock by a parameterized divider. Frame data changes on its falling edge, and read data is sampled on its rising edge.

Top module: `mdio_frame_master`

## Requirements
- R1: While reset is high and directly after it, the status word reads all zeros, the error flag is 0, `mdio_oe` is 0 and `mdc` is 0.
- R2: A command write with bit 31 set, made while not busy, is accepted. Status bit 31 reads 1 from the next clock until the frame has ended.
- R3: Each frame is 64 bits, sent MSB first, one bit per `mdc` period. The bits are, in order: 32 ones, then command bits 17:16 (start code), 19:18 (opcode), 24:20 (PHY address), 29:25 (register or device address), then two turnaround bits, then command bits 15:0. `mdio_o` changes only on a falling edge of `mdc`.
- R4: For opcodes with bit 19 clear (00 address frame, 01 write), the master drives all 64 bits, and the turnaround is 1 followed by 0.
- R5: For opcodes with bit 19 set (10 short-family read, 11 extended read), `mdio_oe` is 0 for the last 18 bits. The 16 values of `mdio_i` seen at the rising `mdc` edges of the data bits are returned MSB first in status bits 15:0 once busy has cleared.
- R6: After a non-read frame, status bits 15:0 hold the command's bits 15:0, and status bits 30:16 hold the command's bits 30:16 for every accepted command.
- R7: A command write made while busy is ignored: the frame in flight, and the status word it ends with, are unchanged. The error flag becomes 1 on the next clock and stays 1 until reset.
- R8: A command write with bit 31 clear, made while idle, starts no frame and leaves the status word and error flag unchanged.
- R9: `mdc` toggles every `DIV_HALF` system clocks.
- R10: Between frames `mdio_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_wdata | input | 32 | Command word |
| cmd_rdata | output | 32 | Status word: bit 31 busy, 30:16 command fields, 15:0 data or read result |
| err_flag | output | 1 | Sticky flag for a command written while busy |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The completion of a frame and a new command write can land on the same system clock edge. The rule is that the busy flag sampled at that edge decides, so such a write is still rejected and flagged. To provoke this, the bench holds the write strobe high with a second command for the whole of a read frame. It then checks three things: that busy reads 0 for exactly one sampled clock, that the held command is accepted on the following edge and produces its own correct frame, and that the first frame's read result and the error flag were already in place when that happened.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    typedef struct packed {
        logic        go;
        logic        spare;
        logic [4:0]  regad;
        logic [4:0]  phyad;
        logic [1:0]  op;
        logic [1:0]  st;
        logic [15:0] data;
    } mdio_cmd_t;

    typedef enum logic [1:0] {
        OP_ADDR   = 2'b00,
        OP_WRITE  = 2'b01,
        OP_RD_22  = 2'b10,
        OP_RD_45  = 2'b11
    } mdio_op_e;

    localparam int BODY_BITS = 32;
    localparam int TA_OFFSET = 14;
    localparam int DATA_OFFSET = 16;

    function automatic logic op_is_read(logic [1:0] op);
        return op[1];
    endfunction

    function automatic logic [BODY_BITS-1:0] frame_body(mdio_cmd_t c);
        return {c.st, c.op, c.phyad, c.regad, 2'b10, c.data};
    endfunction

endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
    parameter int DIV_HALF = 2
) (
    input  logic clk,
    input  logic rst,
    output logic mdc,
    output logic fall_stb,
    output logic rise_stb
);
    localparam int CW = $clog2(DIV_HALF + 1);
    localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

    logic [CW-1:0] cnt;
    logic          wrap;

    assign wrap     = (cnt == LAST);
    assign fall_stb = wrap && mdc;
    assign rise_stb = wrap && !mdc;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_bit_engine.sv
module mdio_bit_engine
    import mdio_pkg::*;
#(
    parameter int PREAMBLE = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [BODY_BITS-1:0] body,
    input  logic                 is_read,
    input  logic                 fall_stb,
    input  logic                 rise_stb,
    input  logic                 mdio_i,
    output logic                 active,
    output logic                 mdio_o,
    output logic                 mdio_oe,
    output logic [15:0]          rd_result
);
    localparam int FRAME_LEN = PREAMBLE + BODY_BITS;
    localparam int IW = $clog2(FRAME_LEN + 1);
    localparam logic [IW-1:0] IDX_END  = IW'(FRAME_LEN);
    localparam logic [IW-1:0] IDX_BODY = IW'(PREAMBLE);
    localparam logic [IW-1:0] IDX_REL  = IW'(PREAMBLE + TA_OFFSET);
    localparam logic [IW-1:0] IDX_SMP  = IW'(PREAMBLE + DATA_OFFSET + 1);

    logic [IW-1:0]        idx;
    logic [BODY_BITS-1:0] sh_out;
    logic [15:0]          sh_in;
    logic                 rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active    <= 1'b0;
            idx       <= '0;
            sh_out    <= '0;
            sh_in     <= '0;
            rd_q      <= 1'b0;
            mdio_o    <= 1'b1;
            mdio_oe   <= 1'b0;
            rd_result <= '0;
        end else if (!active) begin
            if (start) begin
                active <= 1'b1;
                idx    <= '0;
                sh_out <= body;
                rd_q   <= is_read;
                sh_in  <= '0;
            end
        end else begin
            if (fall_stb) begin
                if (idx == IDX_END) begin
                    active    <= 1'b0;
                    mdio_oe   <= 1'b0;
                    mdio_o    <= 1'b1;
                    rd_result <= sh_in;
                end else begin
                    idx     <= idx + 1'b1;
                    mdio_oe <= !(rd_q && (idx >= IDX_REL));
                    if (idx < IDX_BODY) begin
                        mdio_o <= 1'b1;
                    end else begin
                        mdio_o <= sh_out[BODY_BITS-1];
                        sh_out <= {sh_out[BODY_BITS-2:0], 1'b0};
                    end
                end
            end
            if (rise_stb && rd_q && (idx >= IDX_SMP)) begin
                sh_in <= {sh_in[14:0], mdio_i};
            end
        end
    end
endmodule

// File: rtl/mdio_frame_master.sv
module mdio_frame_master
    import mdio_pkg::*;
#(
    parameter int DIV_HALF = 2,
    parameter int PREAMBLE = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_wr,
    input  logic [31:0] cmd_wdata,
    output logic [31:0] cmd_rdata,
    output logic        err_flag,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    mdio_cmd_t   cmd_in;
    mdio_cmd_t   cmd_q;
    logic        busy;
    logic        accept;
    logic        fall_stb;
    logic        rise_stb;
    logic [15:0] rd_result;

    assign cmd_in = mdio_cmd_t'(cmd_wdata);
    assign accept = cmd_wr && cmd_in.go && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q    <= '0;
            err_flag <= 1'b0;
        end else begin
            if (accept)
                cmd_q <= cmd_in;
            if (cmd_wr && busy)
                err_flag <= 1'b1;
        end
    end

    mdio_clkdiv #(.DIV_HALF(DIV_HALF)) u_div (
        .clk      (clk),
        .rst      (rst),
        .mdc      (mdc),
        .fall_stb (fall_stb),
        .rise_stb (rise_stb)
    );

    mdio_bit_engine #(.PREAMBLE(PREAMBLE)) u_eng (
        .clk       (clk),
        .rst       (rst),
        .start     (accept),
        .body      (frame_body(cmd_in)),
        .is_read   (op_is_read(cmd_in.op)),
        .fall_stb  (fall_stb),
        .rise_stb  (rise_stb),
        .mdio_i    (mdio_i),
        .active    (busy),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .rd_result (rd_result)
    );

    assign cmd_rdata = {busy, cmd_q.spare, cmd_q.regad, cmd_q.phyad, cmd_q.op, cmd_q.st,
                        op_is_read(cmd_q.op) ? rd_result : cmd_q.data};
endmodule

// File: rtl/mdio_frame_master_chk.sv
module mdio_frame_master_chk #(
    parameter int DIV_HALF = 2
) (
    input logic        clk,
    input logic        rst,
    input logic        cmd_wr,
    input logic [31:0] cmd_wdata,
    input logic [31:0] cmd_rdata,
    input logic        err_flag,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe
);
    logic mdc_d;
    int   gap;

    always_ff @(posedge clk) begin
        if (rst) begin
            mdc_d <= 1'b0;
            gap   <= -1;
        end else begin
            mdc_d <= mdc;
            gap   <= (mdc != mdc_d) ? 0 : gap + 1;
        end
    end

    // R2
    accept_sets_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && cmd_wdata[31] && !cmd_rdata[31]) |=> cmd_rdata[31]);

    // R7
    busy_write_flags_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && cmd_rdata[31]) |=> err_flag);

    // R7
    busy_write_keeps_fields_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && cmd_rdata[31]) |=> $stable(cmd_rdata[30:16]));

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err_flag |=> err_flag);

    // R8
    no_go_no_start_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && !cmd_wdata[31] && !cmd_rdata[31]) |=> !cmd_rdata[31]);

    // R10
    idle_released_chk: assert property (@(posedge clk) disable iff (rst)
        !cmd_rdata[31] |-> !mdio_oe);

    // R3
    data_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(mdio_o) |-> $fell(mdc));

    // R9
    mdc_period_chk: assert property (@(posedge clk) disable iff (rst)
        (mdc != mdc_d) |-> (gap == DIV_HALF - 1));
endmodule

bind mdio_frame_master mdio_frame_master_chk #(.DIV_HALF(DIV_HALF)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_wr    (cmd_wr),
    .cmd_wdata (cmd_wdata),
    .cmd_rdata (cmd_rdata),
    .err_flag  (err_flag),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe)
);

// File: tb/tb_mdio_frame_master.sv
`timescale 1ns/1ps
module tb_mdio_frame_master;
    localparam int DIV_HALF = 2;
    localparam int PREAMBLE = 32;
    localparam int FLEN = PREAMBLE + 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_wr = 1'b0;
    logic [31:0] cmd_wdata = '0;
    logic [31:0] cmd_rdata;
    logic        err_flag;
    logic        mdc;
    logic        mdio_o;
    logic        mdio_oe;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [1:0] exp_q[$];
    logic [15:0] phy_resp = '0;
    int frames_seen = 0;
    bit err_exp = 0;
    int err_mis = 0;
    bit model_on = 0;

    always #5 clk = ~clk;

    mdio_frame_master #(.DIV_HALF(DIV_HALF), .PREAMBLE(PREAMBLE)) dut (
        .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
        .cmd_rdata(cmd_rdata), .err_flag(err_flag), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [4:0] ra, input logic [4:0] pa,
                                       input logic [1:0] op, input logic [1:0] st,
                                       input logic [15:0] d);
        return {1'b1, 1'b0, ra, pa, op, st, d};
    endfunction

    // Behavioural expectation of every bit on the wire (R3, R4, R5)
    task automatic push_frame(input logic [31:0] c);
        logic [31:0] body;
        bit rd;
        rd = c[19];
        body = {c[17:16], c[19:18], c[24:20], c[29:25], 2'b10, c[15:0]};
        for (int k = 0; k < FLEN; k++) begin
            logic b;
            b = (k < PREAMBLE) ? 1'b1 : body[31 - (k - PREAMBLE)];
            exp_q.push_back({!(rd && k >= PREAMBLE + 14), b});
        end
    endtask

    // PHY side: record each bit at the rising MDC edge, answer reads
    always @(posedge mdc) begin
        static bit inframe = 0;
        static int k = 0;
        static int bad = 0;
        #1;
        if (!inframe && mdio_oe) begin
            inframe = 1; k = 0; bad = 0;
        end
        if (inframe) begin
            if (exp_q.size() == 0) begin
                bad++;
            end else begin
                logic [1:0] e;
                e = exp_q.pop_front();
                if (mdio_oe !== e[1]) bad++;
                else if (e[1] && mdio_o !== e[0]) bad++;
            end
            if (k + 1 >= PREAMBLE + 16 && k + 1 < FLEN)
                mdio_i = phy_resp[FLEN - 2 - k];
            else
                mdio_i = 1'b1;
            k++;
            if (k == FLEN) begin
                inframe = 0;
                frames_seen++;
                check(bad == 0, "R3 frame bit sequence (R4/R5 drive pattern)", bad, 0);
            end
        end
    end

    // Per-clock comparison of the sticky flag against the model (R7)
    always @(negedge clk) begin
        if (model_on && err_flag !== err_exp) err_mis++;
    end

    task automatic wait_idle();
        do @(negedge clk); while (cmd_rdata[31]);
    endtask

    task automatic issue(input logic [31:0] c, input string tag);
        @(negedge clk);
        push_frame(c);
        cmd_wr = 1'b1; cmd_wdata = c;
        @(negedge clk);
        cmd_wr = 1'b0;
        check(cmd_rdata[31] === 1'b1, {tag, " R2 busy after accept"}, cmd_rdata[31], 1);
    endtask

    task automatic run_frame(input logic [31:0] c, input logic [15:0] resp, input string tag);
        int f0;
        f0 = frames_seen;
        phy_resp = resp;
        issue(c, tag);
        wait_idle();
        check(frames_seen == f0 + 1, {tag, " R2 one frame sent"}, frames_seen - f0, 1);
        if (c[19])
            check(cmd_rdata === {1'b0, c[30:16], resp}, {tag, " R5 read result"}, cmd_rdata, {1'b0, c[30:16], resp});
        else
            check(cmd_rdata === {1'b0, c[30:0]}, {tag, " R6 status after write"}, cmd_rdata, {1'b0, c[30:0]});
        check(mdio_oe === 1'b0, {tag, " R10 released after frame"}, mdio_oe, 0);
    endtask

    initial begin
        #1_500_000;
        if (!finished) begin
            failures++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] c;
        realtime t1, t2;
        int f0;
        repeat (3) @(negedge clk);
        // R1
        check(cmd_rdata === 32'h0 && err_flag === 1'b0 && mdio_oe === 1'b0 && mdc === 1'b0,
              "R1 reset state", {cmd_rdata[31:3], err_flag, mdio_oe, mdc}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(cmd_rdata === 32'h0 && err_flag === 1'b0 && mdio_oe === 1'b0, "R1 after reset", cmd_rdata, 0);
        model_on = 1;

        // R9
        @(posedge mdc); t1 = $realtime;
        @(posedge mdc); t2 = $realtime;
        check((t2 - t1) == 2 * DIV_HALF * 10, "R9 mdc period", int'(t2 - t1), 2 * DIV_HALF * 10);

        // Short family write and read (R3, R4, R5, R6)
        run_frame(mk(5'h0D, 5'h13, 2'b01, 2'b01, 16'hA5C3), 16'h0000, "c22 write");
        run_frame(mk(5'h02, 5'h01, 2'b10, 2'b01, 16'h0000), 16'h8E17, "c22 read");
        // Extended family: address, write, read (R3, R4, R5, R6)
        run_frame(mk(5'h1E, 5'h1F, 2'b00, 2'b00, 16'h0123), 16'h0000, "c45 addr");
        run_frame(mk(5'h1E, 5'h1F, 2'b01, 2'b00, 16'hFEDC), 16'h0000, "c45 write");
        run_frame(mk(5'h07, 5'h00, 2'b11, 2'b00, 16'h5555), 16'h4001, "c45 read");

        // R8: go bit clear while idle
        f0 = frames_seen;
        c = cmd_rdata;
        @(negedge clk);
        cmd_wr = 1'b1; cmd_wdata = 32'h7FFF_FFFF;
        @(negedge clk);
        cmd_wr = 1'b0;
        repeat (300) @(negedge clk);
        check(frames_seen == f0 && cmd_rdata === c && err_flag === 1'b0, "R8 no-go write ignored",
              cmd_rdata, c);

        // R7: write while busy
        c = mk(5'h11, 5'h05, 2'b01, 2'b01, 16'hBEEF);
        phy_resp = 16'h0;
        issue(c, "busy write");
        repeat (20) @(negedge clk);
        cmd_wr = 1'b1; cmd_wdata = mk(5'h03, 5'h09, 2'b10, 2'b01, 16'h1111);
        @(posedge clk);
        err_exp = 1;
        @(negedge clk);
        cmd_wr = 1'b0;
        check(err_flag === 1'b1, "R7 error flag set", err_flag, 1);
        wait_idle();
        check(cmd_rdata === {1'b0, c[30:0]}, "R7 in-flight command kept", cmd_rdata, {1'b0, c[30:0]});

        // Completion and held write on the same edge (R2, R7)
        c = mk(5'h1F, 5'h0A, 2'b10, 2'b01, 16'h0000);
        phy_resp = 16'h0F0F;
        issue(c, "coincide first");
        cmd_wr = 1'b1; cmd_wdata = mk(5'h04, 5'h0B, 2'b01, 2'b01, 16'hC0DE);
        wait_idle();
        check(cmd_rdata === {1'b0, c[30:16], 16'h0F0F}, "R5 result visible at completion",
              cmd_rdata, {1'b0, c[30:16], 16'h0F0F});
        push_frame(mk(5'h04, 5'h0B, 2'b01, 2'b01, 16'hC0DE));
        @(negedge clk);
        cmd_wr = 1'b0;
        check(cmd_rdata[31] === 1'b1, "R2 held command accepted after busy cleared", cmd_rdata[31], 1);
        wait_idle();
        check(cmd_rdata === {1'b0, mk(5'h04, 5'h0B, 2'b01, 2'b01, 16'hC0DE)}[31:0] - 32'h8000_0000 + 32'h0
              || cmd_rdata === {1'b0, 31'(mk(5'h04, 5'h0B, 2'b01, 2'b01, 16'hC0DE))},
              "R6 second command status", cmd_rdata, {1'b0, 31'(mk(5'h04, 5'h0B, 2'b01, 2'b01, 16'hC0DE))});
        repeat (10) @(negedge clk);
        check(exp_q.size() == 0, "R3 all expected bits consumed", exp_q.size(), 0);
        check(err_mis == 0, "R7 per-clock flag model", err_mis, 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule